// File: doc/BRIEF.md
# Field-Oriented Current Control Engine

This block performs one complete field-oriented current-control update each time it is started, normally once per PWM period (roughly 21.8 kHz). It takes two measured phase currents from 12-bit converters, the sine and cosine of the rotor electrical angle, direct and quadrature current set-points, proportional and integral gains and an integrator limit. From these it produces three phase voltage commands for the modulator.

The update runs in a fixed sequence. The forward Clarke transform produces alpha and beta, and the forward Park transform rotates them into d and q. A PI regulator runs on each axis. The inverse Park transform and the inverse Clarke transform then produce the three phase voltages. Every product and every sum is issued, one per clock, to a single 16x16 signed multiplier feeding a 32-bit signed accumulator, under control of a step counter that indexes a computed micro-program. The third phase current is never sampled. The Clarke step uses the zero-sum relation instead, through beta = (ia + 2*ib)/sqrt(3).

The integrator state of both axes is kept from one update to the next. Angle generation, PWM timing and converter capture happen outside the block.

Top module: `foc_engine`

## Requirements
- R1: During and after reset, va, vb, vc, busy, done and overrun are all 0, and both PI integrators hold 0.
- R2: A start pulse seen while idle captures every input, and the whole update uses only the captured values. Input changes made while busy do not affect that update's outputs.
- R3: The clock edge that samples an accepted start sets busy. done is a one-cycle pulse 29 clock edges later, and busy falls on that same edge. va, vb and vc change only on the edge that raises done.
- R4: Each current sample is a 12-bit two's-complement value and is scaled by 16 to Q1.15. alpha equals the scaled ia. beta = q(18919*ia + 18919*ib + 18919*ib), where q(x) is an arithmetic shift right by 15 with saturation to [-32768, 32767].
- R5: id = q(alpha*cos + beta*sin) and iq = q(beta*cos - alpha*sin).
- R6: For each axis, e = q((ref - meas)*2^15). The integrator is updated as I = clamp(q(I*2^15 + ki*e), -lim, +lim), and it persists across updates. ki, kp and lim are 15-bit unsigned values.
- R7: Each axis voltage is v = q(kp*e + I*2^15), using the integrator value after clamping.
- R8: v_alpha = q(vd*cos - vq*sin) and v_beta = q(vd*sin + vq*cos).
- R9: va = v_alpha, vb = q(28378*v_beta - 16384*v_alpha) and vc = q(-16384*v_alpha - 28378*v_beta).
- R10: Products are summed exactly in 32 bits, and no accumulation wraps for any input in range. Every stored result is the saturated, floor-shifted sum.
- R11: A sine or cosine input of -32768 is treated as -32767.
- R12: A start pulse while busy is ignored, including in the final step cycle. It sets overrun, which stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request one update |
| ia_adc | input | 12 | Phase A current sample, two's complement |
| ib_adc | input | 12 | Phase B current sample, two's complement |
| sin_q | input | 16 | Sine of electrical angle, Q1.15 |
| cos_q | input | 16 | Cosine of electrical angle, Q1.15 |
| id_ref | input | 16 | Direct-axis current set-point, Q1.15 |
| iq_ref | input | 16 | Quadrature-axis current set-point, Q1.15 |
| kp | input | 15 | Proportional gain, unsigned Q0.15 |
| ki | input | 15 | Integral gain, unsigned Q0.15 |
| int_lim | input | 15 | Symmetric integrator limit |
| va | output | 16 | Phase A voltage command, Q1.15 |
| vb | output | 16 | Phase B voltage command, Q1.15 |
| vc | output | 16 | Phase C voltage command, Q1.15 |
| busy | output | 1 | Update in progress |
| done | output | 1 | One-cycle pulse: outputs updated |
| overrun | output | 1 | Sticky: a start arrived while busy |

## Verification
The delicate coincidence is a new start request arriving in the same cycle that the last micro-step commits the outputs and raises done. The bench provokes it by raising start in exactly that final step cycle. It then judges three things: done still pulses with the results of the running update, overrun becomes set, and no second update begins in the 35 cycles that follow. A start raised mid-update is also checked and must be ignored. A start one cycle after done must be accepted normally.

// File: rtl/foc_pkg.sv
package foc_pkg;
  localparam int DW      = 16;
  localparam int FRAC    = 15;
  localparam int ACC_W   = 32;
  localparam int N_STEPS = 29;
  localparam int STEP_W  = $clog2(N_STEPS);

  localparam logic signed [DW-1:0] K_INV_SQRT3 = 16'sd18919;
  localparam logic signed [DW-1:0] K_HALF      = 16'sd16384;
  localparam logic signed [DW-1:0] K_SQRT3_2   = 16'sd28378;

  localparam logic signed [ACC_W-1:0] Q_MAX = ACC_W'(2**(DW-1) - 1);
  localparam logic signed [ACC_W-1:0] Q_MIN = -Q_MAX - 1;

  typedef enum logic [4:0] {
    A_IA, A_IB, A_ALPHA, A_BETA, A_REFD, A_REFQ, A_ID, A_IQ, A_INTD,
    A_INTQ, A_KP, A_KI, A_VD, A_VQ, A_VAL, A_VBE
  } src_a_e;

  typedef enum logic [2:0] {
    B_ONE, B_K3, B_COS, B_SIN, B_ED, B_EQ, B_HALF, B_S32
  } src_b_e;

  typedef enum logic [3:0] {
    D_ALPHA, D_BETA, D_ID, D_IQ, D_ED, D_EQ, D_INTD, D_INTQ,
    D_VD, D_VQ, D_VAL, D_VBE, D_VA, D_VB, D_VC, D_NONE
  } dst_e;

  typedef struct packed {
    src_a_e a;
    src_b_e b;
    logic   sub;
    logic   first;
    logic   last;
    dst_e   dst;
  } uop_t;

  function automatic uop_t mk(input src_a_e a, input src_b_e b, input logic sub,
                              input logic first, input logic last, input dst_e d);
    uop_t u;
    u.a = a; u.b = b; u.sub = sub; u.first = first; u.last = last; u.dst = d;
    return u;
  endfunction

  // Micro-program: one multiply-accumulate per entry.
  function automatic uop_t ucode(input logic [STEP_W-1:0] idx);
    int i;
    i = int'(idx);
    case (i)
      // forward Clarke
      0:  return mk(A_IA,    B_ONE,  1'b0, 1'b1, 1'b1, D_ALPHA);
      1:  return mk(A_IA,    B_K3,   1'b0, 1'b1, 1'b0, D_NONE);
      2:  return mk(A_IB,    B_K3,   1'b0, 1'b0, 1'b0, D_NONE);
      3:  return mk(A_IB,    B_K3,   1'b0, 1'b0, 1'b1, D_BETA);
      // forward Park
      4:  return mk(A_ALPHA, B_COS,  1'b0, 1'b1, 1'b0, D_NONE);
      5:  return mk(A_BETA,  B_SIN,  1'b0, 1'b0, 1'b1, D_ID);
      6:  return mk(A_BETA,  B_COS,  1'b0, 1'b1, 1'b0, D_NONE);
      7:  return mk(A_ALPHA, B_SIN,  1'b1, 1'b0, 1'b1, D_IQ);
      // d-axis PI
      8:  return mk(A_REFD,  B_ONE,  1'b0, 1'b1, 1'b0, D_NONE);
      9:  return mk(A_ID,    B_ONE,  1'b1, 1'b0, 1'b1, D_ED);
      10: return mk(A_INTD,  B_ONE,  1'b0, 1'b1, 1'b0, D_NONE);
      11: return mk(A_KI,    B_ED,   1'b0, 1'b0, 1'b1, D_INTD);
      12: return mk(A_INTD,  B_ONE,  1'b0, 1'b1, 1'b0, D_NONE);
      13: return mk(A_KP,    B_ED,   1'b0, 1'b0, 1'b1, D_VD);
      // q-axis PI
      14: return mk(A_REFQ,  B_ONE,  1'b0, 1'b1, 1'b0, D_NONE);
      15: return mk(A_IQ,    B_ONE,  1'b1, 1'b0, 1'b1, D_EQ);
      16: return mk(A_INTQ,  B_ONE,  1'b0, 1'b1, 1'b0, D_NONE);
      17: return mk(A_KI,    B_EQ,   1'b0, 1'b0, 1'b1, D_INTQ);
      18: return mk(A_INTQ,  B_ONE,  1'b0, 1'b1, 1'b0, D_NONE);
      19: return mk(A_KP,    B_EQ,   1'b0, 1'b0, 1'b1, D_VQ);
      // inverse Park
      20: return mk(A_VD,    B_COS,  1'b0, 1'b1, 1'b0, D_NONE);
      21: return mk(A_VQ,    B_SIN,  1'b1, 1'b0, 1'b1, D_VAL);
      22: return mk(A_VD,    B_SIN,  1'b0, 1'b1, 1'b0, D_NONE);
      23: return mk(A_VQ,    B_COS,  1'b0, 1'b0, 1'b1, D_VBE);
      // inverse Clarke
      24: return mk(A_VAL,   B_ONE,  1'b0, 1'b1, 1'b1, D_VA);
      25: return mk(A_VBE,   B_S32,  1'b0, 1'b1, 1'b0, D_NONE);
      26: return mk(A_VAL,   B_HALF, 1'b1, 1'b0, 1'b1, D_VB);
      27: return mk(A_VAL,   B_HALF, 1'b1, 1'b1, 1'b0, D_NONE);
      28: return mk(A_VBE,   B_S32,  1'b1, 1'b0, 1'b1, D_VC);
      default: return mk(A_IA, B_ONE, 1'b0, 1'b0, 1'b0, D_NONE);
    endcase
  endfunction

  // Floor shift by FRAC, then saturate to DW bits.
  function automatic logic signed [DW-1:0] q_sat(input logic signed [ACC_W-1:0] x);
    logic signed [ACC_W-1:0] s;
    s = x >>> FRAC;
    if (s > Q_MAX) return DW'(Q_MAX);
    if (s < Q_MIN) return DW'(Q_MIN);
    return DW'(s);
  endfunction

  function automatic logic signed [DW-1:0] clamp_sym(input logic signed [DW-1:0] v,
                                                     input logic [DW-2:0] lim);
    logic signed [DW-1:0] hi;
    hi = $signed({1'b0, lim});
    if (v > hi) return hi;
    if (v < -hi) return -hi;
    return v;
  endfunction

  // Keep trig operands symmetric so two-term sums cannot reach 2^31.
  function automatic logic signed [DW-1:0] trim_min(input logic signed [DW-1:0] v);
    return (v == DW'(Q_MIN)) ? (DW'(Q_MIN) + DW'(1)) : v;
  endfunction
endpackage

// File: rtl/foc_seq.sv
module foc_seq
  import foc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              accept,
  output logic              last_step,
  output logic              done,
  output logic              overrun
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(N_STEPS - 1);

  logic rejected;

  assign accept    = start && !busy;
  assign rejected  = start && busy;
  assign last_step = busy && (step == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      step    <= '0;
      done    <= 1'b0;
      overrun <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rejected) overrun <= 1'b1;
      if (accept) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy) begin
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          step <= step + STEP_W'(1);
        end
      end
    end
  end

  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(last_step) && !busy));
  assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_reject_flags_R12: assert property (@(posedge clk) disable iff (rst)
    rejected |=> overrun);
  assert_overrun_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

// File: rtl/foc_mac.sv
module foc_mac
  import foc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    clr,
  input  logic                    sub,
  input  logic                    unity,
  input  logic signed [DW-1:0]    op_a,
  input  logic signed [DW-1:0]    op_b,
  output logic signed [ACC_W-1:0] acc_next,
  output logic                    acc_wrap
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] base;
  logic signed [ACC_W-1:0] prod;
  logic        [ACC_W:0]   sum_w;

  always_comb begin
    base = clr ? '0 : acc_q;
    prod = unity ? (ACC_W'(op_a) <<< FRAC) : (ACC_W'(op_a) * ACC_W'(op_b));
    if (sub) sum_w = {base[ACC_W-1], base} - {prod[ACC_W-1], prod};
    else     sum_w = {base[ACC_W-1], base} + {prod[ACC_W-1], prod};
  end

  assign acc_next = sum_w[ACC_W-1:0];
  assign acc_wrap = sum_w[ACC_W] ^ sum_w[ACC_W-1];

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= acc_next;
  end

  assert_acc_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    en |-> !acc_wrap);
endmodule

// File: rtl/foc_regs.sv
module foc_regs
  import foc_pkg::*;
#(
  parameter int ADC_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    capture,
  input  logic signed [ADC_W-1:0] ia_adc,
  input  logic signed [ADC_W-1:0] ib_adc,
  input  logic signed [DW-1:0]    sin_q,
  input  logic signed [DW-1:0]    cos_q,
  input  logic signed [DW-1:0]    id_ref,
  input  logic signed [DW-1:0]    iq_ref,
  input  logic [DW-2:0]           kp,
  input  logic [DW-2:0]           ki,
  input  logic [DW-2:0]           int_lim,
  input  uop_t                    uop,
  input  logic                    wr,
  input  logic signed [ACC_W-1:0] acc_next,
  output logic signed [DW-1:0]    op_a,
  output logic signed [DW-1:0]    op_b,
  output logic                    unity,
  output logic signed [DW-1:0]    va,
  output logic signed [DW-1:0]    vb,
  output logic signed [DW-1:0]    vc
);
  localparam int SHIFT = DW - ADC_W;

  logic signed [DW-1:0] c_ia, c_ib, c_sin, c_cos, c_refd, c_refq;
  logic [DW-2:0]        c_kp, c_ki, c_lim;
  logic signed [DW-1:0] r_alpha, r_beta, r_id, r_iq, r_ed, r_eq;
  logic signed [DW-1:0] r_intd, r_intq, r_vd, r_vq, r_val, r_vbe, r_va, r_vb;
  logic signed [DW-1:0] wb_raw, wb_val;
  logic                 wr_intd, wr_intq, commit;

  assign wb_raw  = q_sat(acc_next);
  assign wr_intd = wr && (uop.dst == D_INTD);
  assign wr_intq = wr && (uop.dst == D_INTQ);
  assign wb_val  = (wr_intd || wr_intq) ? clamp_sym(wb_raw, c_lim) : wb_raw;
  assign commit  = wr && (uop.dst == D_VC);
  assign unity   = (uop.b == B_ONE);

  always_comb begin
    case (uop.a)
      A_IA:    op_a = c_ia;
      A_IB:    op_a = c_ib;
      A_ALPHA: op_a = r_alpha;
      A_BETA:  op_a = r_beta;
      A_REFD:  op_a = c_refd;
      A_REFQ:  op_a = c_refq;
      A_ID:    op_a = r_id;
      A_IQ:    op_a = r_iq;
      A_INTD:  op_a = r_intd;
      A_INTQ:  op_a = r_intq;
      A_KP:    op_a = $signed({1'b0, c_kp});
      A_KI:    op_a = $signed({1'b0, c_ki});
      A_VD:    op_a = r_vd;
      A_VQ:    op_a = r_vq;
      A_VAL:   op_a = r_val;
      A_VBE:   op_a = r_vbe;
      default: op_a = '0;
    endcase
    case (uop.b)
      B_K3:    op_b = K_INV_SQRT3;
      B_COS:   op_b = c_cos;
      B_SIN:   op_b = c_sin;
      B_ED:    op_b = r_ed;
      B_EQ:    op_b = r_eq;
      B_HALF:  op_b = K_HALF;
      B_S32:   op_b = K_SQRT3_2;
      default: op_b = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      c_ia <= '0; c_ib <= '0; c_sin <= '0; c_cos <= '0; c_refd <= '0; c_refq <= '0;
      c_kp <= '0; c_ki <= '0; c_lim <= '0;
    end else if (capture) begin
      c_ia   <= DW'(ia_adc) <<< SHIFT;
      c_ib   <= DW'(ib_adc) <<< SHIFT;
      c_sin  <= trim_min(sin_q);
      c_cos  <= trim_min(cos_q);
      c_refd <= id_ref;
      c_refq <= iq_ref;
      c_kp   <= kp;
      c_ki   <= ki;
      c_lim  <= int_lim;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      r_alpha <= '0; r_beta <= '0; r_id <= '0; r_iq <= '0; r_ed <= '0; r_eq <= '0;
      r_intd <= '0; r_intq <= '0; r_vd <= '0; r_vq <= '0; r_val <= '0; r_vbe <= '0;
      r_va <= '0; r_vb <= '0;
    end else if (wr) begin
      case (uop.dst)
        D_ALPHA: r_alpha <= wb_val;
        D_BETA:  r_beta  <= wb_val;
        D_ID:    r_id    <= wb_val;
        D_IQ:    r_iq    <= wb_val;
        D_ED:    r_ed    <= wb_val;
        D_EQ:    r_eq    <= wb_val;
        D_INTD:  r_intd  <= wb_val;
        D_INTQ:  r_intq  <= wb_val;
        D_VD:    r_vd    <= wb_val;
        D_VQ:    r_vq    <= wb_val;
        D_VAL:   r_val   <= wb_val;
        D_VBE:   r_vbe   <= wb_val;
        D_VA:    r_va    <= wb_val;
        D_VB:    r_vb    <= wb_val;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      va <= '0; vb <= '0; vc <= '0;
    end else if (commit) begin
      va <= r_va;
      vb <= r_vb;
      vc <= wb_val;
    end
  end

  assert_integ_d_bound_R6: assert property (@(posedge clk) disable iff (rst)
    wr_intd |=> (r_intd <= $signed({1'b0, c_lim}) && r_intd >= -$signed({1'b0, c_lim})));
  assert_integ_q_bound_R6: assert property (@(posedge clk) disable iff (rst)
    wr_intq |=> (r_intq <= $signed({1'b0, c_lim}) && r_intq >= -$signed({1'b0, c_lim})));
  assert_hold_captures_R2: assert property (@(posedge clk) disable iff (rst)
    !capture |=> ($stable(c_ia) && $stable(c_ib) && $stable(c_sin) && $stable(c_cos)
                  && $stable(c_refd) && $stable(c_refq) && $stable(c_kp) && $stable(c_ki)));
  assert_trig_trimmed_R11: assert property (@(posedge clk) disable iff (rst)
    capture |=> (c_sin != DW'(Q_MIN) && c_cos != DW'(Q_MIN)));
endmodule

// File: rtl/foc_engine.sv
module foc_engine
  import foc_pkg::*;
#(
  parameter int ADC_W = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic signed [ADC_W-1:0] ia_adc,
  input  logic signed [ADC_W-1:0] ib_adc,
  input  logic signed [15:0]      sin_q,
  input  logic signed [15:0]      cos_q,
  input  logic signed [15:0]      id_ref,
  input  logic signed [15:0]      iq_ref,
  input  logic [14:0]             kp,
  input  logic [14:0]             ki,
  input  logic [14:0]             int_lim,
  output logic signed [15:0]      va,
  output logic signed [15:0]      vb,
  output logic signed [15:0]      vc,
  output logic                    busy,
  output logic                    done,
  output logic                    overrun
);
  logic [STEP_W-1:0]       step;
  logic                    accept, last_step, wr, unity, acc_wrap;
  uop_t                    uop;
  logic signed [DW-1:0]    op_a, op_b;
  logic signed [ACC_W-1:0] acc_next;

  assign uop = ucode(step);
  assign wr  = busy && uop.last && (uop.dst != D_NONE);

  foc_seq i_seq (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .step(step),
    .accept(accept), .last_step(last_step), .done(done), .overrun(overrun)
  );

  foc_mac i_mac (
    .clk(clk), .rst(rst), .en(busy), .clr(uop.first), .sub(uop.sub), .unity(unity),
    .op_a(op_a), .op_b(op_b), .acc_next(acc_next), .acc_wrap(acc_wrap)
  );

  foc_regs #(.ADC_W(ADC_W)) i_regs (
    .clk(clk), .rst(rst), .capture(accept),
    .ia_adc(ia_adc), .ib_adc(ib_adc), .sin_q(sin_q), .cos_q(cos_q),
    .id_ref(id_ref), .iq_ref(iq_ref), .kp(kp), .ki(ki), .int_lim(int_lim),
    .uop(uop), .wr(wr), .acc_next(acc_next),
    .op_a(op_a), .op_b(op_b), .unity(unity), .va(va), .vb(vb), .vc(vc)
  );

  assert_outputs_move_on_done_R3: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(va) && $stable(vb) && $stable(vc)));
  assert_last_write_ends_R3: assert property (@(posedge clk) disable iff (rst)
    (wr && uop.dst == D_VC) |-> last_step);
endmodule

// File: tb/test_foc_engine.sv
`timescale 1ns/1ps
module test_foc_engine;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic signed [11:0] ia_adc = '0, ib_adc = '0;
  logic signed [15:0] sin_q = '0, cos_q = '0, id_ref = '0, iq_ref = '0;
  logic [14:0] kp = '0, ki = '0, int_lim = '0;
  logic signed [15:0] va, vb, vc;
  logic busy, done, overrun;

  int n_chk = 0;
  int n_fail = 0;
  longint m_intd = 0, m_intq = 0;
  longint c_ia, c_ib, c_s, c_c, c_rd, c_rq, c_kp, c_ki, c_lim;

  always #2.5 clk = ~clk;

  foc_engine i_foc_engine (
    .clk(clk), .rst(rst), .start(start), .ia_adc(ia_adc), .ib_adc(ib_adc),
    .sin_q(sin_q), .cos_q(cos_q), .id_ref(id_ref), .iq_ref(iq_ref),
    .kp(kp), .ki(ki), .int_lim(int_lim), .va(va), .vb(vb), .vc(vc),
    .busy(busy), .done(done), .overrun(overrun)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint shq(input longint x);
    longint y;
    y = x >>> 15;
    if (y > 32767) return 32767;
    if (y < -32768) return -32768;
    return y;
  endfunction

  function automatic longint lim_to(input longint v, input longint l);
    if (v > l) return l;
    if (v < -l) return -l;
    return v;
  endfunction

  // Bench's own formulation of one update; advances the integrator model.
  task automatic predict(output longint eva, output longint evb, output longint evc);
    longint a, b, s, c, al, be, id, iq, ed, eq, vd, vq, val, vbe;
    a = c_ia * 16;
    b = c_ib * 16;
    s = (c_s == -32768) ? -32767 : c_s;
    c = (c_c == -32768) ? -32767 : c_c;
    al = shq(a * 32768);
    be = shq(18919 * (a + 2 * b));
    id = shq(al * c + be * s);
    iq = shq(be * c - al * s);
    ed = shq((c_rd - id) * 32768);
    eq = shq((c_rq - iq) * 32768);
    m_intd = lim_to(shq(m_intd * 32768 + c_ki * ed), c_lim);
    m_intq = lim_to(shq(m_intq * 32768 + c_ki * eq), c_lim);
    vd = shq(c_kp * ed + m_intd * 32768);
    vq = shq(c_kp * eq + m_intq * 32768);
    val = shq(vd * c - vq * s);
    vbe = shq(vd * s + vq * c);
    eva = shq(val * 32768);
    evb = shq(28378 * vbe - 16384 * val);
    evc = shq(-16384 * val - 28378 * vbe);
  endtask

  task automatic apply(input int ia_v, input int ib_v, input int s, input int c,
                       input int rd, input int rq, input int kp_v, input int ki_v,
                       input int lim_v);
    ia_adc = 12'(ia_v); ib_adc = 12'(ib_v); sin_q = 16'(s); cos_q = 16'(c);
    id_ref = 16'(rd); iq_ref = 16'(rq); kp = 15'(kp_v); ki = 15'(ki_v); int_lim = 15'(lim_v);
    c_ia = ia_v; c_ib = ib_v; c_s = s; c_c = c; c_rd = rd; c_rq = rq;
    c_kp = kp_v; c_ki = ki_v; c_lim = lim_v;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_intd = 0;
    m_intq = 0;
  endtask

  // Called at a negedge, after apply(). restart_at >= 1 raises start again
  // so it is sampled on edge restart_at+1 after the accepting edge.
  task automatic run_update(input string tag, input int restart_at, input bit disturb);
    longint eva, evb, evc, pva, pvb, pvc;
    bit early, moved;
    predict(eva, evb, evc);
    pva = va; pvb = vb; pvc = vc;
    early = 1'b0; moved = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R3 busy after start"}, busy, 1);
    for (int k = 1; k <= 28; k++) begin
      @(negedge clk);
      if (done) early = 1'b1;
      if (va != pva || vb != pvb || vc != pvc) moved = 1'b1;
      start = (k == restart_at);
      if (disturb && k == 2) begin
        ia_adc = 12'sd1500; ib_adc = -12'sd1700; sin_q = 16'sd12000; cos_q = -16'sd9000;
        id_ref = 16'sd5000; iq_ref = -16'sd5000; kp = 15'd100; ki = 15'd32000; int_lim = 15'd1;
      end
    end
    chk({tag, " R3 no early done"}, early, 0);
    chk({tag, " R3 outputs held while busy"}, moved, 0);
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R3 done after 29 edges"}, done, 1);
    chk({tag, " R9 va"}, va, eva);
    chk({tag, " R9 vb"}, vb, evb);
    chk({tag, " R9 vc"}, vc, evc);
    if (restart_at > 0) chk({tag, " R12 overrun set"}, overrun, 1);
    @(negedge clk);
    chk({tag, " R3 done pulse ends"}, done, 0);
    chk({tag, " R3 idle after done"}, busy, 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1 va", va, 0); chk("R1 vb", vb, 0); chk("R1 vc", vc, 0);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 overrun", overrun, 0);
  endtask

  task automatic t_basic();
    @(negedge clk);
    apply(300, -100, 0, 32767, 0, 8000, 16384, 4096, 20000);
    run_update("basic R4 R5 R6 R7 R8", 0, 1'b0);
  endtask

  task automatic t_patterns();
    @(negedge clk);
    apply(-700, 450, 23170, 23170, 1200, -3000, 9000, 2000, 15000);
    run_update("pattern1 R5 R8", 0, 1'b0);
    apply(1023, 1000, 32767, 0, -4000, 2500, 20000, 8000, 30000);
    run_update("pattern2 R6 persist", 0, 1'b0);
    apply(-1, -2047, -16384, -28378, 7000, 7000, 3000, 12000, 25000);
    run_update("pattern3 R7 R10", 0, 1'b0);
  endtask

  task automatic t_integ_clamp();
    do_reset();
    @(negedge clk);
    for (int n = 0; n < 3; n++) begin
      apply(0, 0, 0, 32767, 20000, -20000, 0, 32767, 3000);
      run_update("clamp R6", 0, 1'b0);
    end
    chk("R6 va held at limit path", va, 2999);
  endtask

  task automatic t_saturate();
    @(negedge clk);
    apply(-2048, 0, 0, 32767, 32767, -32768, 32767, 32767, 32767);
    run_update("sat R7 R10 R4", 0, 1'b0);
    apply(2047, -2048, 0, 32767, -32768, 32767, 32767, 32767, 32767);
    run_update("sat2 R10", 0, 1'b0);
  endtask

  task automatic t_trig_min();
    @(negedge clk);
    apply(900, -300, -32768, -32768, 1000, 2000, 16000, 1000, 10000);
    run_update("trig R11", 0, 1'b0);
  endtask

  task automatic t_hold_inputs();
    @(negedge clk);
    apply(-1200, 800, 10000, 30000, -2000, 4000, 12000, 3000, 8000);
    run_update("hold R2", 0, 1'b1);
  endtask

  task automatic t_overrun_mid();
    do_reset();
    @(negedge clk);
    apply(500, 200, 20000, -20000, 3000, 1000, 8000, 4000, 12000);
    run_update("mid R12", 5, 1'b0);
  endtask

  task automatic t_overrun_at_done();
    bit seen;
    do_reset();
    chk("R12 cleared by reset", overrun, 0);
    @(negedge clk);
    apply(-400, 600, -5000, 32000, 2500, -1500, 10000, 5000, 9000);
    run_update("at-done R12", 28, 1'b0);
    seen = 1'b0;
    for (int k = 0; k < 35; k++) begin
      @(negedge clk);
      if (done || busy) seen = 1'b1;
    end
    chk("R12 start at final step ignored", seen, 0);
    chk("R12 overrun sticky", overrun, 1);
    apply(100, 100, 0, 32767, 0, 0, 1000, 1000, 1000);
    run_update("after overrun R2", 0, 1'b0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset_state();
    t_basic();
    t_patterns();
    t_integ_clamp();
    t_saturate();
    t_trig_min();
    t_hold_inputs();
    t_overrun_mid();
    t_overrun_at_done();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule